// File: doc/BRIEF.md
# Two-Dimensional DMA Address Sequencer

This block is the address engine of a single DMA channel. Software sets up a line length, a line stride, a line count, a direction bit and a burst-mode bit. It then writes a start word address, and that write launches the transfer. The block issues one 32-bit-word address per cycle on a valid/ready handshake, and a bus master downstream consumes the addresses. All quantities are counted in words, and the start address is the byte address shifted right by two.

A non-zero line length selects strided mode. In this mode each line covers `line_len` consecutive words. Each new line starts `stride` words after the start of the previous line, so a stride larger than the line length skips the gap between lines. The line-count field holds the number of lines minus one.

A line length of zero selects ring mode. The address climbs through an area of `stride × (line count + 1)` words and then returns to the start address. The area has two equal halves, and the end of each half raises an event. Ring mode runs until `stop` is asserted. `stop` aborts either mode at once.

Top module: `dma2d_addr_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `addr_valid`, `done_evt` and `half_evt` are low.
- R2: When `start_we` is high in idle and `stop` is low, the next cycle shows `addr_valid` high with `addr_out` equal to `start_addr`. `addr_dir` and `addr_burst` then show the `cfg_dir` and `cfg_burst` values captured in that cycle.
- R3: In strided mode the k-th accepted address is `start + (k / len) * stride + (k % len)`. Exactly `len * (lines_m1 + 1)` addresses are issued.
- R4: While `addr_valid` is high and `addr_ready` is low, `addr_out` and `addr_valid` hold in the next cycle. An address advances only on an accepted handshake.
- R5: In the cycle after the last strided address is accepted, `done_evt` is high for exactly one cycle and `addr_valid` is low.
- R6: With `cfg_line_len` = 0, the k-th accepted address is `start + (k mod area)`, where area = `stride * (lines_m1 + 1)`. The run continues until stop.
- R7: In ring mode, `half_evt` pulses for one cycle after the word at offset `area/2 - 1` is accepted, and again after the word at offset `area - 1` is accepted.
- R8: In the cycle after `stop` is high, `addr_valid`, `done_evt` and `half_evt` are low. This holds even when a handshake or a `start_we` happens in the same cycle as the stop.
- R9: A `start_we` while a transfer is running is ignored, and the address sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_we | input | 1 | Start-address write; launches a transfer when idle |
| start_addr | input | AW | Start word address |
| cfg_line_len | input | LW | Words per line; 0 selects ring mode |
| cfg_stride | input | LW | Words between successive line starts |
| cfg_lines_m1 | input | LW | Number of lines minus one |
| cfg_dir | input | 1 | Direction bit, carried to `addr_dir` |
| cfg_burst | input | 1 | Burst-mode bit, carried to `addr_burst` |
| stop | input | 1 | Abort; returns to idle |
| addr_valid | output | 1 | Address available |
| addr_ready | input | 1 | Consumer accepts the address |
| addr_out | output | AW | Current word address |
| addr_dir | output | 1 | Latched direction |
| addr_burst | output | 1 | Latched burst mode |
| done_evt | output | 1 | One-cycle pulse at the end of a strided transfer |
| half_evt | output | 1 | One-cycle pulse at the end of each ring half |

## Verification
On every cycle the assertions check the local rules. These are: the hold of a stalled address, unit steps within a line, the stride jump between lines, the return to base on a wrap, the silence after stop, and that only one event fires at a time. Only the bench scenarios can show the whole address sequences, because those depend on the history of handshakes. The bench compares complete strided and ring sequences against a formula under a stall pattern. It also checks the exact cycle in which done and half events fire, and confirms that a start write in mid-transfer and a stop in the same cycle as a handshake both behave as the requirements state.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STRIDE = 2'd1,
    ST_RING   = 2'd2
  } dma2d_state_e;
endpackage

// File: rtl/dma2d_stride_seq.sv
module dma2d_stride_seq #(
  parameter int AW = 30,
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] len,
  input  logic [LW-1:0] stride,
  input  logic [LW-1:0] lines_m1,
  input  logic          adv,
  output logic [AW-1:0] addr,
  output logic          at_last
);
  logic [AW-1:0] cur, base;
  logic [LW-1:0] xcnt, ycnt, len_m1, stride_q, lines_q;
  logic          line_end;

  assign line_end = (xcnt == len_m1);
  assign at_last  = line_end && (ycnt == lines_q);
  assign addr     = cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0; base <= '0; xcnt <= '0; ycnt <= '0;
      len_m1 <= '0; stride_q <= '0; lines_q <= '0;
    end else if (load) begin
      cur      <= start_addr;
      base     <= start_addr;
      xcnt     <= '0;
      ycnt     <= '0;
      len_m1   <= len - LW'(1);
      stride_q <= stride;
      lines_q  <= lines_m1;
    end else if (adv) begin
      if (line_end) begin
        if (!at_last) begin
          base <= base + AW'(stride_q);
          cur  <= base + AW'(stride_q);
          xcnt <= '0;
          ycnt <= ycnt + LW'(1);
        end
      end else begin
        cur  <= cur + AW'(1);
        xcnt <= xcnt + LW'(1);
      end
    end
  end

  // R3: unit step inside a line
  a_r3_unit_step: assert property (@(posedge clk) disable iff (rst)
    adv && !load && !line_end |=> cur == $past(cur) + AW'(1));
  // R3: next line begins one stride after the previous line start
  a_r3_line_jump: assert property (@(posedge clk) disable iff (rst)
    adv && !load && line_end && !at_last |=> cur == $past(base) + AW'($past(stride_q)));
endmodule

// File: rtl/dma2d_ring_seq.sv
module dma2d_ring_seq #(
  parameter int AW = 30,
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] stride,
  input  logic [LW-1:0] lines_m1,
  input  logic          adv,
  output logic [AW-1:0] addr,
  output logic          at_half,
  output logic          at_wrap
);
  localparam int ARW = 2*LW + 1;

  logic [AW-1:0]  cur, base;
  logic [ARW-1:0] off, area_m1, half_m1, area_w;

  assign area_w  = ARW'(stride) * (ARW'(lines_m1) + ARW'(1));
  assign at_half = (off == half_m1);
  assign at_wrap = (off == area_m1);
  assign addr    = cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0; base <= '0; off <= '0; area_m1 <= '0; half_m1 <= '0;
    end else if (load) begin
      cur     <= start_addr;
      base    <= start_addr;
      off     <= '0;
      area_m1 <= area_w - ARW'(1);
      half_m1 <= (area_w >> 1) - ARW'(1);
    end else if (adv) begin
      if (at_wrap) begin
        off <= '0;
        cur <= base;
      end else begin
        off <= off + ARW'(1);
        cur <= cur + AW'(1);
      end
    end
  end

  // R6: accepting the last word of the area returns to the start address
  a_r6_wrap_base: assert property (@(posedge clk) disable iff (rst)
    adv && !load && at_wrap |=> (cur == base) && (off == '0));
  // R6: otherwise the ring climbs by one word
  a_r6_climb: assert property (@(posedge clk) disable iff (rst)
    adv && !load && !at_wrap |=> cur == $past(cur) + AW'(1));
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int AW = 30,
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_we,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] cfg_line_len,
  input  logic [LW-1:0] cfg_stride,
  input  logic [LW-1:0] cfg_lines_m1,
  input  logic          cfg_dir,
  input  logic          cfg_burst,
  input  logic          stop,
  output logic          addr_valid,
  input  logic          addr_ready,
  output logic [AW-1:0] addr_out,
  output logic          addr_dir,
  output logic          addr_burst,
  output logic          done_evt,
  output logic          half_evt
);
  dma2d_state_e  state;
  logic          hs, load, adv_s, adv_r, s_last, r_half, r_wrap;
  logic [AW-1:0] s_addr, r_addr;

  assign addr_valid = (state != ST_IDLE);
  assign hs         = addr_valid && addr_ready;
  assign load       = start_we && (state == ST_IDLE) && !stop;
  assign adv_s      = hs && (state == ST_STRIDE);
  assign adv_r      = hs && (state == ST_RING);
  assign addr_out   = (state == ST_RING) ? r_addr : s_addr;

  dma2d_stride_seq #(.AW(AW), .LW(LW)) u_stride (
    .clk(clk), .rst(rst), .load(load), .start_addr(start_addr),
    .len(cfg_line_len), .stride(cfg_stride), .lines_m1(cfg_lines_m1),
    .adv(adv_s), .addr(s_addr), .at_last(s_last)
  );

  dma2d_ring_seq #(.AW(AW), .LW(LW)) u_ring (
    .clk(clk), .rst(rst), .load(load), .start_addr(start_addr),
    .stride(cfg_stride), .lines_m1(cfg_lines_m1),
    .adv(adv_r), .addr(r_addr), .at_half(r_half), .at_wrap(r_wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      addr_dir   <= 1'b0;
      addr_burst <= 1'b0;
      done_evt   <= 1'b0;
      half_evt   <= 1'b0;
    end else begin
      done_evt <= !stop && adv_s && s_last;
      half_evt <= !stop && adv_r && (r_half || r_wrap);
      if (stop) begin
        state <= ST_IDLE;
      end else if (load) begin
        state      <= (cfg_line_len == '0) ? ST_RING : ST_STRIDE;
        addr_dir   <= cfg_dir;
        addr_burst <= cfg_burst;
      end else if (adv_s && s_last) begin
        state <= ST_IDLE;
      end
    end
  end

  // R1: reset clears the outputs
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> !addr_valid && !done_evt && !half_evt);
  // R2: launch shows the start address
  a_r2_launch: assert property (@(posedge clk) disable iff (rst)
    load |=> addr_valid && (addr_out == $past(start_addr)));
  // R4: a stalled address holds
  a_r4_stall_hold: assert property (@(posedge clk) disable iff (rst)
    addr_valid && !addr_ready && !stop |=> addr_valid && $stable(addr_out));
  // R5: done coincides with idle
  a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_evt |-> !addr_valid);
  // R8: stop silences the channel
  a_r8_stop_quiet: assert property (@(posedge clk) disable iff (rst)
    stop |=> !addr_valid && !done_evt && !half_evt);
  // R7: events are mutually exclusive single pulses
  a_r7_one_event: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_evt, half_evt}));
  // R9: busy channel ignores a start write
  a_r9_no_relaunch: assert property (@(posedge clk) disable iff (rst)
    addr_valid && start_we && !addr_ready && !stop |=> $stable(addr_out));
endmodule

// File: tb/test_dma2d_addr_gen.sv
`timescale 1ns/1ps
module test_dma2d_addr_gen;
  localparam int AW = 30;
  localparam int LW = 12;
  localparam int NV = 4;
  // columns: line length, stride, lines minus one, start, expected last address
  localparam int VEC [NV][5] = '{
    '{4, 4, 0, 'h100,   'h103},
    '{3, 8, 2, 'h40,    'h52},
    '{1, 5, 3, 'h10,    'h1F},
    '{5, 5, 1, 'h3FFF0, 'h3FFF9}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic start_we = 1'b0, stop = 1'b0, addr_ready = 1'b0;
  logic cfg_dir = 1'b0, cfg_burst = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [LW-1:0] cfg_line_len = '0, cfg_stride = '0, cfg_lines_m1 = '0;
  logic addr_valid, addr_dir, addr_burst, done_evt, half_evt;
  logic [AW-1:0] addr_out;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  dma2d_addr_gen #(.AW(AW), .LW(LW)) i_dma2d_addr_gen (
    .clk(clk), .rst(rst), .start_we(start_we), .start_addr(start_addr),
    .cfg_line_len(cfg_line_len), .cfg_stride(cfg_stride), .cfg_lines_m1(cfg_lines_m1),
    .cfg_dir(cfg_dir), .cfg_burst(cfg_burst), .stop(stop),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_out(addr_out),
    .addr_dir(addr_dir), .addr_burst(addr_burst),
    .done_evt(done_evt), .half_evt(half_evt)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic launch(input int len, stride, lines, start, input bit d, b);
    @(negedge clk);
    cfg_line_len = LW'(len); cfg_stride = LW'(stride); cfg_lines_m1 = LW'(lines);
    cfg_dir = d; cfg_burst = b; start_addr = AW'(start); start_we = 1'b1;
    @(negedge clk);
    start_we = 1'b0;
    check(addr_valid === 1'b1, "R2 valid", addr_valid, 1);
    check(addr_out === AW'(start), "R2 start", addr_out, start);
    check(addr_dir === d && addr_burst === b, "R2 dir/burst", {addr_dir, addr_burst}, {d, b});
  endtask

  task automatic run_strided(input int len, stride, lines, start, exp_last, input bit d, b, inject);
    int total, k, guard;
    logic [AW-1:0] exp, prev, last_acc;
    bit rdy;
    total = len * (lines + 1); k = 0; guard = 0; last_acc = '0;
    launch(len, stride, lines, start, d, b);
    while (k < total && guard < 2000) begin
      guard++;
      rdy = (cyc % 4) != 3; cyc++;
      addr_ready = rdy;
      exp = AW'(start + (k / len) * stride + (k % len));
      check(addr_valid === 1'b1 && addr_out === exp, "R3 address", addr_out, exp);
      check(done_evt === 1'b0, "R5 early done", done_evt, 0);
      if (inject && k == 2) begin start_we = 1'b1; start_addr = AW'('h777); end  // R9
      prev = addr_out;
      @(negedge clk);
      start_we = 1'b0;
      if (!rdy) check(addr_out === prev, "R4 stall hold", addr_out, prev);
      else begin last_acc = exp; k++; end
    end
    check(last_acc === AW'(exp_last), "R3 last address", last_acc, exp_last);
    check(done_evt === 1'b1 && addr_valid === 1'b0, "R5 done/idle", {done_evt, addr_valid}, 2);
    @(negedge clk);
    check(done_evt === 1'b0, "R5 single pulse", done_evt, 0);
    addr_ready = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    int area, k;
    bit rdy, exp_half;
    logic [AW-1:0] exp;
    addr_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(addr_valid === 1'b0 && done_evt === 1'b0 && half_evt === 1'b0, "R1 in reset",
          {addr_valid, done_evt, half_evt}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(addr_valid === 1'b0 && done_evt === 1'b0 && half_evt === 1'b0, "R1 after reset",
          {addr_valid, done_evt, half_evt}, 0);

    // Strided table walk (R2, R3, R4, R5); entry 1 also injects a start write (R9)
    for (int i = 0; i < NV; i++)
      run_strided(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4],
                  i[0], i[1], i == 1);

    // Ring mode: stride 4, two lines -> area 8, halves end at offsets 3 and 7 (R6, R7)
    area = 8; k = 0; exp_half = 1'b0;
    launch(0, 4, 1, 'h200, 1'b1, 1'b1);
    while (k < 19) begin
      rdy = (cyc % 3) != 2; cyc++;
      addr_ready = rdy;
      exp = AW'('h200 + (k % area));
      check(addr_out === exp && addr_valid === 1'b1, "R6 ring address", addr_out, exp);
      check(half_evt === exp_half, "R7 half event", half_evt, exp_half);
      check(done_evt === 1'b0, "R7 no done in ring", done_evt, 0);
      exp_half = rdy && ((k % area) == area/2 - 1 || (k % area) == area - 1);
      @(negedge clk);
      if (rdy) k++;
    end
    check(half_evt === exp_half, "R7 half event", half_evt, exp_half);
    // k = 19 -> offset 3: stop together with an accepted half-end word (R8)
    addr_ready = 1'b1; stop = 1'b1;
    check(addr_out === AW'('h203), "R8 pre-stop address", addr_out, 'h203);
    @(negedge clk);
    stop = 1'b0;
    check(addr_valid === 1'b0 && half_evt === 1'b0 && done_evt === 1'b0, "R8 stop quiet",
          {addr_valid, half_evt, done_evt}, 0);

    // Stop wins over a simultaneous start write (R8)
    cfg_line_len = LW'(2); start_addr = AW'('h300); start_we = 1'b1; stop = 1'b1;
    @(negedge clk);
    start_we = 1'b0; stop = 1'b0;
    check(addr_valid === 1'b0, "R8 stop over start", addr_valid, 0);
    @(negedge clk);
    check(addr_valid === 1'b0, "R8 still idle", addr_valid, 0);

    // Stop in the middle of a strided transfer suppresses done (R8)
    launch(2, 2, 0, 'h80, 1'b0, 1'b0);
    addr_ready = 1'b1;
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check(addr_valid === 1'b0 && done_evt === 1'b0, "R8 strided abort", {addr_valid, done_evt}, 0);
    report();
  end
endmodule